// File: doc/BRIEF.md
# Packet-DMA Channel Control Register Block

This block holds the software-visible control state of a two-channel packet-DMA disk controller. A simple memory-mapped bus with byte, halfword and word accesses reaches one register window per channel and one global key byte. Each window holds a control word, a status byte, a packet count, a next-packet pointer and two FIFO thresholds. The count, pointer, thresholds and transfer-mode bits are presented to the packet engine as plain configuration outputs.

The block turns control-word writes into one-cycle start and abort pulses and a level hold signal for the packet engine. It collects completion and error events from the engine into sticky status flags and drives one shared interrupt line. A start is honoured only while the global key byte holds its unlock value. Setting the channel reset bit holds the engine idle until software writes the control word again with that bit clear. Reading the status byte returns the flags and clears them in the same access.

The taskfile area below the channel windows belongs to other logic. Here it reads as zero and ignores writes.

Top module: `pktdma_regs`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `eng_start`, `eng_abort` and `eng_hold` are all low.
- R2: Channel c's window starts at 0x80 + 0x20*c. Within it, the control halfword is at 0x00, the status byte at 0x02, the packet count halfword at 0x04, the next-packet pointer word at 0x0C, the input FIFO threshold halfword at 0x14 and the output FIFO threshold halfword at 0x16. Every other address, including 0x00-0x7F, reads 0 and ignores writes.
- R3: `bus_size` selects the access width: 0 is a byte, 1 a halfword and 2 a word. Accesses are naturally aligned, and data is right-justified on `bus_wdata` and `bus_rdata`. A write changes only the bytes it addresses.
- R4: The key byte at 0xC7 reads back what was last written to it. A start request is ignored unless that byte holds 7.
- R5: A write to control byte 0 with bit 7 set starts the channel when three conditions hold: the key holds 7, the written bit 5 is 0 and the channel is idle. The start raises that channel's `eng_start` for exactly the one cycle after the write, and the channel becomes busy. Control bit 7 always reads 0.
- R6: Control bit 5 drives `eng_hold` and makes the channel idle. While it is written as 1, a start request is ignored. Rewriting control byte 0 with bit 5 clear releases the hold, and a later start is accepted.
- R7: A write to control byte 0 with bit 7 clear while the channel is busy raises `eng_abort` for one cycle and makes the channel idle. The same write while the channel is idle gives no abort pulse.
- R8: Engine event bits map into the status byte as follows: `eng_evt[4c+0]` sets bit 0 (error), `[4c+1]` sets bit 1 (done), `[4c+2]` sets bit 4 (unexpected interrupt) and `[4c+3]` sets bit 6 (protocol fault). Flags stay set until read. Any event ends the busy state.
- R9: A read whose bytes include the status byte returns the flags and clears them. An event arriving in the same cycle as that read is kept for the next read.
- R10: `irq` is high exactly when some channel has a nonzero status byte and its control bit 8 is 0.
- R11: Read data appears on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read request.
- R12: Channels are independent. An access or event for one channel leaves the other channel's registers and pulses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Right-justified read data |
| bus_rvalid | output | 1 | Read data valid |
| eng_evt | input | NCH*4 | Per-channel engine event bits |
| eng_start | output | NCH | One-cycle start pulse per channel |
| eng_abort | output | NCH | One-cycle abort pulse per channel |
| eng_hold | output | NCH | Engine held idle by reset bit |
| xfer_mode | output | NCH*4 | Control bits 3:0 per channel |
| pkt_count | output | NCH*16 | Packet count per channel |
| pkt_next | output | NCH*32 | Next-packet pointer per channel |
| fifo_in_thr | output | NCH*16 | Input FIFO threshold per channel |
| fifo_out_thr | output | NCH*16 | Output FIFO threshold per channel |
| irq | output | 1 | Shared interrupt |

## Verification
The assertions assume that every bus access is naturally aligned to its size and that the size code is never 3. A misaligned halfword or word would split across register words in ways the lane logic does not define. The random stimulus derives its address from the drawn size by clearing the low bits. The directed cases use aligned addresses only. Engine events are driven only in cycles set apart from start writes, except in the one case that deliberately puts an event and a status read in the same cycle.

// File: rtl/pktdma_pkg.sv
// Shared constants, types and helpers for the packet-DMA channel registers.
// Assumes an 8-bit-or-wider byte address and a 32-bit data path.
package pktdma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam int unsigned CH_BASE  = 32'h80;
    localparam int unsigned CH_SHIFT = 5;
    localparam int unsigned KEY_ADDR = 32'hC7;
    localparam logic [7:0]  KEY_OPEN = 8'h07;
    localparam int unsigned EVW      = 4;

    // word indices inside a channel window
    localparam logic [2:0] W_CTRL  = 3'd0;
    localparam logic [2:0] W_COUNT = 3'd1;
    localparam logic [2:0] W_NEXT  = 3'd3;
    localparam logic [2:0] W_FIFO  = 3'd5;

    // control bit positions
    localparam int unsigned CB_MASK = 8;
    localparam int unsigned CB_GO   = 7;
    localparam int unsigned CB_RST  = 5;

    // place engine event bits into status-byte positions
    function automatic logic [7:0] evt_to_status(input logic [EVW-1:0] e);
        return {1'b0, e[3], 1'b0, e[2], 2'b00, e[1], e[0]};
    endfunction

    // replace the bytes of old selected by be with those of nw
    function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                               input logic [31:0] nw,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = be[i] ? nw[8*i +: 8] : old[8*i +: 8];
        return r;
    endfunction

endpackage

// File: rtl/pktdma_decode.sv
// Address decoder: turns one bus request into channel/key selects, a word
// index, byte enables and lane-aligned write data.
// Assumes naturally aligned accesses and a size code of 0, 1 or 2.
module pktdma_decode
    import pktdma_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic           req,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [1:0]     size,
    input  logic [31:0]    wdata,
    output logic [NCH-1:0] ch_sel,
    output logic           key_sel,
    output logic           wr,
    output logic           rd,
    output logic [2:0]     widx,
    output logic [3:0]     be,
    output logic [31:0]    wlane
);
    localparam int BW = AW - CH_SHIFT;
    localparam int KW = AW - 2;
    localparam logic [KW-1:0] KEY_WORD = KW'(KEY_ADDR >> 2);

    assign wr    = req & we;
    assign rd    = req & ~we;
    assign widx  = addr[4:2];
    assign wlane = wdata << {addr[1:0], 3'b000};
    assign key_sel = req && (addr[AW-1:2] == KEY_WORD);

    // byte enables from access size and low address bits
    always_comb begin
        case (size)
            SZ_BYTE: be = 4'b0001 << addr[1:0];
            SZ_HALF: be = addr[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: be = 4'b1111;
            default: be = 4'b0000;
        endcase
    end

    // one comparator per channel window
    for (genvar c = 0; c < NCH; c++) begin : g_win
        localparam logic [BW-1:0] BLK = BW'(int'(CH_BASE >> CH_SHIFT) + c);
        assign ch_sel[c] = req && (addr[AW-1:CH_SHIFT] == BLK);
    end

endmodule

// File: rtl/pktdma_chan.sv
// One channel's register window: control, status, count, next pointer and
// FIFO thresholds, plus start/abort/hold generation and event capture.
// Assumes the decoder qualifies sel/wr/rd and supplies lane-aligned data.
module pktdma_chan
    import pktdma_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr,
    input  logic            rd,
    input  logic [2:0]      widx,
    input  logic [3:0]      be,
    input  logic [31:0]     wlane,
    input  logic            key_ok,
    input  logic [EVW-1:0]  evt,
    output logic [31:0]     rword,
    output logic            start_o,
    output logic            abort_o,
    output logic            hold_o,
    output logic            irq_o,
    output logic [3:0]      mode_o,
    output logic [15:0]     count_o,
    output logic [31:0]     next_o,
    output logic [15:0]     fin_o,
    output logic [15:0]     fout_o
);
    logic [15:0] ctrl_q, ctrl_n;
    logic [7:0]  stat_q, evt_flags;
    logic [15:0] cnt_q, fin_q, fout_q;
    logic [31:0] ptr_q;
    logic        busy_q, busy_n;
    logic        start_q, abort_q;
    logic        ctrl_wr, lo_wr, go_req, new_rst, start_fire, abort_fire;
    logic        stat_rd, evt_any;
    logic [31:0] fifo_m, cnt_m;

    assign ctrl_wr    = sel & wr & (widx == W_CTRL);
    assign lo_wr      = ctrl_wr & be[0];
    assign go_req     = lo_wr & wlane[CB_GO];
    assign new_rst    = lo_wr ? wlane[CB_RST] : ctrl_q[CB_RST];
    assign start_fire = go_req & key_ok & ~new_rst & ~busy_q;
    assign abort_fire = lo_wr & ~wlane[CB_GO] & busy_q;
    assign stat_rd    = sel & rd & (widx == W_CTRL) & be[2];
    assign evt_flags  = evt_to_status(evt);
    assign evt_any    = |evt;
    assign fifo_m     = lane_merge({fout_q, fin_q}, wlane, be);
    assign cnt_m      = lane_merge({16'h0000, cnt_q}, wlane, {2'b00, be[1:0]});

    // next control value; the start bit is never stored
    always_comb begin
        ctrl_n = ctrl_q;
        if (ctrl_wr && be[0]) ctrl_n[7:0]  = wlane[7:0];
        if (ctrl_wr && be[1]) ctrl_n[15:8] = wlane[15:8];
        ctrl_n[CB_GO] = 1'b0;
    end

    // busy tracking: start sets, abort/event/hold clear
    always_comb begin
        if (start_fire) busy_n = 1'b1;
        else            busy_n = busy_q & ~abort_fire & ~evt_any & ~ctrl_n[CB_RST];
    end

    // control word, busy flag and engine pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_n;
            busy_q  <= busy_n;
            start_q <= start_fire;
            abort_q <= abort_fire;
        end
    end

    // sticky status flags, cleared by a covering read, events win
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~{8{stat_rd}}) | evt_flags;
    end

    // configuration registers with byte-lane writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ptr_q  <= '0;
            fin_q  <= '0;
            fout_q <= '0;
        end else if (sel && wr) begin
            if (widx == W_COUNT) cnt_q <= cnt_m[15:0];
            if (widx == W_NEXT)  ptr_q <= lane_merge(ptr_q, wlane, be);
            if (widx == W_FIFO) begin
                fin_q  <= fifo_m[15:0];
                fout_q <= fifo_m[31:16];
            end
        end
    end

    // read word selected by word index
    always_comb begin
        case (widx)
            W_CTRL:  rword = {8'h00, stat_q, ctrl_q};
            W_COUNT: rword = {16'h0000, cnt_q};
            W_NEXT:  rword = ptr_q;
            W_FIFO:  rword = {fout_q, fin_q};
            default: rword = 32'h0;
        endcase
    end

    assign start_o = start_q;
    assign abort_o = abort_q;
    assign hold_o  = ctrl_q[CB_RST];
    assign irq_o   = (|stat_q) & ~ctrl_q[CB_MASK];
    assign mode_o  = ctrl_q[3:0];
    assign count_o = cnt_q;
    assign next_o  = ptr_q;
    assign fin_o   = fin_q;
    assign fout_o  = fout_q;

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R4
    start_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(key_ok));
    // R6
    hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !ctrl_q[CB_RST]);
    // R7
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> !start_q);
    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (stat_q == $past(evt_flags)));
    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/pktdma_regs.sv
// Top of the packet-DMA channel register block: decoder, NCH channel
// windows, the global start key byte, registered read path and shared irq.
// Assumes one-cycle requests that are naturally aligned to their size.
module pktdma_regs
    import pktdma_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NCH*EVW-1:0] eng_evt,
    output logic [NCH-1:0]    eng_start,
    output logic [NCH-1:0]    eng_abort,
    output logic [NCH-1:0]    eng_hold,
    output logic [NCH*4-1:0]  xfer_mode,
    output logic [NCH*16-1:0] pkt_count,
    output logic [NCH*32-1:0] pkt_next,
    output logic [NCH*16-1:0] fifo_in_thr,
    output logic [NCH*16-1:0] fifo_out_thr,
    output logic              irq
);
    logic [NCH-1:0] ch_sel, ch_irq;
    logic           key_sel, wr, rd;
    logic [2:0]     widx;
    logic [3:0]     be;
    logic [31:0]    wlane, sel_word, rmask;
    logic [31:0]    ch_word [NCH];
    logic [7:0]     key_q;
    logic           key_ok;
    logic [31:0]    rdata_q;
    logic           rvalid_q;

    pktdma_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .size    (bus_size),
        .wdata   (bus_wdata),
        .ch_sel  (ch_sel),
        .key_sel (key_sel),
        .wr      (wr),
        .rd      (rd),
        .widx    (widx),
        .be      (be),
        .wlane   (wlane)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pktdma_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (ch_sel[c]),
            .wr      (wr),
            .rd      (rd),
            .widx    (widx),
            .be      (be),
            .wlane   (wlane),
            .key_ok  (key_ok),
            .evt     (eng_evt[EVW*c +: EVW]),
            .rword   (ch_word[c]),
            .start_o (eng_start[c]),
            .abort_o (eng_abort[c]),
            .hold_o  (eng_hold[c]),
            .irq_o   (ch_irq[c]),
            .mode_o  (xfer_mode[4*c +: 4]),
            .count_o (pkt_count[16*c +: 16]),
            .next_o  (pkt_next[32*c +: 32]),
            .fin_o   (fifo_in_thr[16*c +: 16]),
            .fout_o  (fifo_out_thr[16*c +: 16])
        );
    end

    // global start key byte lives in lane 3 of its word
    always_ff @(posedge clk) begin
        if (!rst_n)                  key_q <= '0;
        else if (key_sel && wr && be[3]) key_q <= wlane[31:24];
    end
    assign key_ok = (key_q == KEY_OPEN);

    // select the addressed word for a read
    always_comb begin
        sel_word = '0;
        for (int c = 0; c < NCH; c++)
            if (ch_sel[c]) sel_word = sel_word | ch_word[c];
        if (key_sel) sel_word = {key_q, 24'h000000};
    end

    // width mask for right-justified read data
    always_comb begin
        case (bus_size)
            SZ_BYTE: rmask = 32'h0000_00FF;
            SZ_HALF: rmask = 32'h0000_FFFF;
            SZ_WORD: rmask = 32'hFFFF_FFFF;
            default: rmask = 32'h0;
        endcase
    end

    // registered read path, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= (sel_word >> {bus_addr[1:0], 3'b000}) & rmask;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign irq        = |ch_irq;

    // R3
    bus_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((bus_size != 2'd3) &&
                     ((bus_size != SZ_HALF) || !bus_addr[0]) &&
                     ((bus_size != SZ_WORD) || (bus_addr[1:0] == 2'b00))));
    // R11
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));
    // R11
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

endmodule

// File: tb/pktdma_regs_bench.sv
// Self-checking bench: byte-image model of the register map, random aligned
// accesses from a fixed seed, then directed start/abort/hold/event cases.
module pktdma_regs_bench;
    localparam int NCH = 2;
    localparam int AW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCH*4-1:0]  eng_evt = '0;
    logic [NCH-1:0]    eng_start, eng_abort, eng_hold;
    logic [NCH*4-1:0]  xfer_mode;
    logic [NCH*16-1:0] pkt_count, fifo_in_thr, fifo_out_thr;
    logic [NCH*32-1:0] pkt_next;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] img [256];

    always #10 clk = ~clk;

    pktdma_regs #(.NCH(NCH), .AW(AW)) u_pktdma_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .eng_evt(eng_evt),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_hold(eng_hold),
        .xfer_mode(xfer_mode), .pkt_count(pkt_count), .pkt_next(pkt_next),
        .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr), .irq(irq)
    );

    // writable bits of each byte address
    function automatic logic [7:0] wmask(input logic [7:0] a);
        logic [4:0] off;
        if (a == 8'hC7) return 8'hFF;
        if (a < 8'h80 || a >= 8'hC0) return 8'h00;
        off = a[4:0];
        case (off)
            5'h00: return 8'h7F;
            5'h01, 5'h04, 5'h05: return 8'hFF;
            5'h0C, 5'h0D, 5'h0E, 5'h0F: return 8'hFF;
            5'h14, 5'h15, 5'h16, 5'h17: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] ev_map(input logic [3:0] e);
        return {1'b0, e[3], 1'b0, e[2], 2'b00, e[1], e[0]};
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < NCH; c++)
            if (img[8'h82 + 8'(32*c)] != 8'h00 && !img[8'h81 + 8'(32*c)][0]) r = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        logic [7:0] b;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        for (int i = 0; i < (1 << s); i++) begin
            b = a + 8'(i);
            img[b] = (img[b] & ~wmask(b)) | (d[8*i +: 8] & wmask(b));
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [1:0] s, input logic [7:0] ev,
                          output logic [31:0] got, output logic [31:0] exp);
        logic [7:0] b;
        exp = '0;
        for (int i = 0; i < (1 << s); i++) exp[8*i +: 8] = img[a + 8'(i)];
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = s; eng_evt = ev;
        @(negedge clk);
        bus_req = 1'b0; eng_evt = '0;
        got = bus_rdata;
        chk("R11 rvalid", 32'(bus_rvalid), 32'd1);
        for (int i = 0; i < (1 << s); i++) begin
            b = a + 8'(i);
            if (b == 8'h82 || b == 8'hA2) img[b] = 8'h00;
        end
        for (int c = 0; c < NCH; c++)
            img[8'h82 + 8'(32*c)] = img[8'h82 + 8'(32*c)] | ev_map(ev[4*c +: 4]);
    endtask

    task automatic ev_pulse(input int c, input logic [3:0] e);
        @(negedge clk);
        eng_evt[4*c +: 4] = e;
        @(negedge clk);
        eng_evt = '0;
        img[8'h82 + 8'(32*c)] = img[8'h82 + 8'(32*c)] | ev_map(e);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [1:0] s);
        logic [31:0] got, exp;
        bus_rd(a, s, 8'h00, got, exp);
        chk(req, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] got, exp, dummy;
        logic [1:0]  s;
        logic [7:0]  a;
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        dummy = $urandom(32'h0000_5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 start", 32'(eng_start), 32'd0);
        chk("R1 hold", 32'(eng_hold), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        rd_chk("R1 ctrl ch0", 8'h80, 2'd2);
        rd_chk("R1 next ch1", 8'hAC, 2'd2);
        rd_chk("R1 fifo ch1", 8'hB4, 2'd2);

        // R2 R3 directed lane writes
        bus_wr(8'h8C, 2'd2, 32'hDEAD_BEEF);
        rd_chk("R2 next word", 8'h8C, 2'd2);
        rd_chk("R3 byte read", 8'h8E, 2'd0);
        bus_wr(8'h8C, 2'd1, 32'h0000_1234);
        rd_chk("R3 half write", 8'h8C, 2'd2);
        bus_wr(8'h94, 2'd1, 32'h0000_0100);
        bus_wr(8'h96, 2'd1, 32'h0000_0100);
        bus_wr(8'h84, 2'd1, 32'h0000_0001);
        chk("R2 fifo out port", 32'(fifo_out_thr[15:0]), 32'h100);
        chk("R2 count port", 32'(pkt_count[15:0]), 32'h1);
        chk("R12 ch1 count", 32'(pkt_count[31:16]), 32'h0);
        bus_wr(8'h10, 2'd2, 32'hFFFF_FFFF);
        rd_chk("R2 taskfile area", 8'h10, 2'd2);

        // R2 R3 random aligned traffic
        for (int n = 0; n < 400; n++) begin
            s = 2'($urandom % 3);
            a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(8'h80 + ($urandom % 8'h48));
            a = a & ~8'((1 << s) - 1);
            if ($urandom % 2 == 0) bus_wr(a, s, $urandom);
            else rd_chk("R3 random read", a, s);
        end
        chk("R10 irq random", 32'(irq), 32'(exp_irq()));

        // return both channels to idle and close the key
        bus_wr(8'h80, 2'd1, 32'h0);
        bus_wr(8'hA0, 2'd1, 32'h0);
        bus_wr(8'hC7, 2'd0, 32'h0);

        // R4 start ignored without key
        bus_wr(8'h80, 2'd1, 32'h0083);
        chk("R4 locked start", 32'(eng_start), 32'd0);
        rd_chk("R5 go reads zero", 8'h80, 2'd1);
        bus_wr(8'hC7, 2'd0, 32'h07);
        rd_chk("R4 key readback", 8'hC7, 2'd0);

        // R5 start pulse
        bus_wr(8'h80, 2'd0, 32'h83);
        chk("R5 start ch0", 32'(eng_start), 32'b01);
        @(negedge clk);
        chk("R5 start one cycle", 32'(eng_start), 32'd0);

        // R7 abort while busy, none while idle
        bus_wr(8'h80, 2'd0, 32'h03);
        chk("R7 abort busy", 32'(eng_abort), 32'b01);
        bus_wr(8'h80, 2'd0, 32'h03);
        chk("R7 no abort idle", 32'(eng_abort), 32'd0);

        // R6 reset bit holds and blocks start
        bus_wr(8'h80, 2'd0, 32'h23);
        chk("R6 hold on", 32'(eng_hold), 32'b01);
        bus_wr(8'h80, 2'd0, 32'hA3);
        chk("R6 start blocked", 32'(eng_start), 32'd0);
        bus_wr(8'h80, 2'd0, 32'h03);
        chk("R6 hold off", 32'(eng_hold), 32'd0);
        bus_wr(8'h80, 2'd0, 32'h83);
        chk("R6 start after release", 32'(eng_start), 32'b01);

        // R8 done event ends busy and sets flag
        ev_pulse(0, 4'b0010);
        chk("R10 irq done", 32'(irq), 32'd1);
        bus_wr(8'h80, 2'd0, 32'h03);
        chk("R8 event ends busy", 32'(eng_abort), 32'd0);
        rd_chk("R9 status read", 8'h82, 2'd0);
        rd_chk("R9 status cleared", 8'h82, 2'd0);
        chk("R10 irq cleared", 32'(irq), 32'd0);

        // R10 masking across channels; R12 independence
        bus_wr(8'h80, 2'd1, 32'h0103);
        ev_pulse(1, 4'b1101);
        chk("R10 irq ch1", 32'(irq), 32'd1);
        rd_chk("R8 ch1 flags", 8'hA2, 2'd1);
        ev_pulse(0, 4'b0001);
        chk("R10 masked", 32'(irq), 32'd0);
        bus_wr(8'h80, 2'd1, 32'h0003);
        chk("R10 unmasked", 32'(irq), 32'(exp_irq()));
        rd_chk("R9 word read clears", 8'h80, 2'd2);
        chk("R10 after clear", 32'(irq), 32'd0);

        // R9 event in the same cycle as the clearing read
        bus_rd(8'h82, 2'd0, 8'h08, got, exp);
        chk("R9 same-cycle read", got, exp);
        rd_chk("R9 event kept", 8'h82, 2'd0);
        rd_chk("R12 ch1 ctrl", 8'hA0, 2'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule